// File: doc/BRIEF.md
# Program/Erase Operation Status Controller

This block is the status front end of a flash program/erase engine. It takes already-decoded commands (program, erase, suspend, resume, clear-status), decides whether each one may run, and tracks one operation through idle, running, suspended and reset-abort states. The array work itself is stood in for by a down-counter whose length depends on the operation kind. A busy output, an 8-bit status word and a one-cycle reject pulse report the outcome to the host.

A protect input acts as a write enable. A program or erase presented while it is low is refused and flagged. If it falls while an operation runs, the operation ends and is reported as failed. A reset that arrives while an operation is running keeps busy high for a short drain period, and that period can end before reset is released. A reset taken while idle or suspended never raises busy.

Top module: `pe_status_ctrl`

## Requirements
- R1: With the controller idle and `wp_en` high, opcode 1 (program) or opcode 2 (erase) is accepted. `busy_o` is high for exactly `PROG_CYCLES` or `ERASE_CYCLES` clock cycles, starting in the cycle after the command. Status bit 7 reads 1 when not busy and 0 when busy.
- R2: While an operation is running, every command other than opcode 3 (suspend) produces `cmd_reject_o` high for exactly one cycle, in the cycle after the command, and the operation continues.
- R3: Opcode 3 taken while running releases `busy_o` in the next cycle and sets status bit 6. Opcode 4 (resume) then raises busy again for the cycles that were still left. The cycle in which the suspend is taken does no work, so the remaining count is the run length minus the busy cycles that came before that cycle.
- R4: Opcode 1 or 2 with `wp_en` low while idle sets status bit 3. It does not raise busy and does not pulse `cmd_reject_o`.
- R5: If `wp_en` is low in any running cycle, the operation stops and busy falls in the next cycle. The failure is recorded in status bit 4 for a program or status bit 5 for an erase.
- R6: Status bits 3, 4 and 5 stay set until opcode 5 (clear-status) is accepted. Opcode 5 is accepted while idle or suspended and rejected while running.
- R7: If reset (`rst_n` low) is sampled while an operation is running, busy stays high for exactly `ABORT_CYCLES` cycles and then falls, even if reset is still held. Reset clears status bits 3 to 5.
- R8: If reset is sampled while idle or suspended, busy stays low and any suspended operation is discarded. Commands presented during reset have no effect.
- R9: While idle, opcodes 3 and 4 and any opcode outside 1 to 5 are rejected. While suspended, opcodes 1, 2 and 3 are rejected. Each command has exactly one outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode: 1 program, 2 erase, 3 suspend, 4 resume, 5 clear-status |
| wp_en | input | 1 | Protect input; high allows program and erase |
| busy_o | output | 1 | High while an operation runs or a reset drains |
| status_o | output | 8 | Bit 7 ready, 6 suspended, 5 erase fail, 4 program fail, 3 protect violation |
| cmd_reject_o | output | 1 | One-cycle pulse for a refused command |

## Verification
A vector table runs every opcode from the idle state with the protect input both high and low. Each vector tells apart an accepted start, a protect refusal (status bit set, no pulse) and a state refusal (pulse, no status change). Directed sequences then measure busy lengths cycle by cycle for a plain run, for a run split by suspend and resume, for a run cut short by a protect drop, and for a reset that lands on a running operation. Each of these lengths separates a correct count from an off-by-one. A reset landing on a suspended or idle controller checks that busy never rises and that the suspended work is discarded.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROGRAM = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4,
    OP_CLRSTAT = 3'd5
  } pe_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_SUSP  = 2'd2,
    ST_ABORT = 2'd3
  } pe_state_e;

  localparam int unsigned SB_READY = 7;
  localparam int unsigned SB_SUSP  = 6;
  localparam int unsigned SB_EFAIL = 5;
  localparam int unsigned SB_PFAIL = 4;
  localparam int unsigned SB_PROT  = 3;

  typedef struct packed {
    logic start_prog;
    logic start_erase;
    logic suspend;
    logic resume;
    logic clear;
    logic prot_viol;
    logic reject;
  } pe_verdict_t;

endpackage

// File: rtl/pe_cmd_judge.sv
module pe_cmd_judge
  import pe_status_pkg::*;
(
  input  pe_state_e   state_i,
  input  logic        cmd_valid_i,
  input  logic [2:0]  cmd_op_i,
  input  logic        wp_en_i,
  output pe_verdict_t verdict_o
);

  function automatic pe_verdict_t judge(pe_state_e st, logic [2:0] op, logic wp);
    pe_verdict_t v;
    v = '0;
    case (st)
      ST_IDLE: begin
        case (pe_op_e'(op))
          OP_PROGRAM: if (wp) v.start_prog  = 1'b1; else v.prot_viol = 1'b1;
          OP_ERASE:   if (wp) v.start_erase = 1'b1; else v.prot_viol = 1'b1;
          OP_CLRSTAT: v.clear  = 1'b1;
          default:    v.reject = 1'b1;
        endcase
      end
      ST_BUSY: begin
        if (pe_op_e'(op) == OP_SUSPEND) v.suspend = 1'b1;
        else                            v.reject  = 1'b1;
      end
      ST_SUSP: begin
        case (pe_op_e'(op))
          OP_RESUME:  v.resume = 1'b1;
          OP_CLRSTAT: v.clear  = 1'b1;
          default:    v.reject = 1'b1;
        endcase
      end
      default: v.reject = 1'b1;
    endcase
    return v;
  endfunction

  always_comb begin
    verdict_o = '0;
    if (cmd_valid_i) verdict_o = judge(state_i, cmd_op_i, wp_en_i);
  end

  // R9: a command never has two outcomes at once
  always_comb begin
    if (cmd_valid_i)
      a_r9_one_outcome: assert ($onehot0(verdict_o));
  end

endmodule

// File: rtl/pe_op_counter.sv
module pe_op_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_cnt(logic [CNT_W-1:0] cur, logic ld,
                                                logic [CNT_W-1:0] val, logic run);
    if (ld)                          return val;
    if (run && cur != '0)            return cur - 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    cnt_q <= next_cnt(cnt_q, load_i, load_val_i, run_i);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pe_status_ctrl.sv
module pe_status_ctrl
  import pe_status_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 4,
  parameter int unsigned ERASE_CYCLES = 10,
  parameter int unsigned ABORT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       wp_en,
  output logic       busy_o,
  output logic [7:0] status_o,
  output logic       cmd_reject_o
);

  localparam int unsigned MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned MAX_CYC = (MAX_A > ABORT_CYCLES) ? MAX_A : ABORT_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  pe_state_e        state_q;
  logic             op_erase_q;
  logic             prot_q, pfail_q, efail_q, reject_q;
  pe_verdict_t      verdict;
  logic             cmd_live;
  logic             wp_drop;
  logic             cnt_load, cnt_run, cnt_last;
  logic [CNT_W-1:0] cnt_val, cnt;

  assign cmd_live = cmd_valid && rst_n;
  assign wp_drop  = (state_q == ST_BUSY) && !wp_en;

  pe_cmd_judge u_judge (
    .state_i     (state_q),
    .cmd_valid_i (cmd_live),
    .cmd_op_i    (cmd_op),
    .wp_en_i     (wp_en),
    .verdict_o   (verdict)
  );

  assign cnt_load = rst_n ? (verdict.start_prog || verdict.start_erase)
                          : (state_q == ST_BUSY);
  assign cnt_val  = !rst_n              ? CNT_W'(ABORT_CYCLES) :
                    verdict.start_erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
  assign cnt_run  = (state_q == ST_ABORT) ||
                    (rst_n && state_q == ST_BUSY && !wp_drop && !verdict.suspend);

  pe_op_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .run_i      (cnt_run),
    .cnt_o      (cnt),
    .last_o     (cnt_last)
  );

  always_ff @(posedge clk) begin
    reject_q <= 1'b0;
    if (!rst_n) begin
      prot_q  <= 1'b0;
      pfail_q <= 1'b0;
      efail_q <= 1'b0;
      if (state_q == ST_BUSY)                    state_q <= ST_ABORT;
      else if (state_q == ST_ABORT && !cnt_last) state_q <= ST_ABORT;
      else                                       state_q <= ST_IDLE;
    end else begin
      if (verdict.reject)    reject_q <= 1'b1;
      if (verdict.prot_viol) prot_q   <= 1'b1;
      if (verdict.clear) begin
        prot_q  <= 1'b0;
        pfail_q <= 1'b0;
        efail_q <= 1'b0;
      end
      case (state_q)
        ST_IDLE: begin
          if (verdict.start_prog) begin
            state_q    <= ST_BUSY;
            op_erase_q <= 1'b0;
          end else if (verdict.start_erase) begin
            state_q    <= ST_BUSY;
            op_erase_q <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (wp_drop) begin
            state_q <= ST_IDLE;
            if (op_erase_q) efail_q <= 1'b1;
            else            pfail_q <= 1'b1;
          end else if (verdict.suspend) begin
            state_q <= ST_SUSP;
          end else if (cnt_last) begin
            state_q <= ST_IDLE;
          end
        end
        ST_SUSP:  if (verdict.resume) state_q <= ST_BUSY;
        default:  if (cnt_last)       state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q == ST_BUSY) || (state_q == ST_ABORT);
  assign cmd_reject_o = reject_q;

  always_comb begin
    status_o           = '0;
    status_o[SB_READY] = !busy_o;
    status_o[SB_SUSP]  = (state_q == ST_SUSP);
    status_o[SB_EFAIL] = efail_q;
    status_o[SB_PFAIL] = pfail_q;
    status_o[SB_PROT]  = prot_q;
  end

  // R1: a running operation always has work left in the counter
  a_r1_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> (cnt != '0));

  // R2: non-suspend command while running is refused
  a_r2_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && cmd_valid && cmd_op != 3'(OP_SUSPEND)) |=> cmd_reject_o);

  // R3: suspended work is frozen until resume
  a_r3_susp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP && !(cmd_valid && cmd_op == 3'(OP_RESUME))) |=> $stable(cnt));

  // R4: protected start leaves the block idle and flags bit 3
  a_r4_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd_valid && !wp_en &&
     (cmd_op == 3'(OP_PROGRAM) || cmd_op == 3'(OP_ERASE))) |=> (!busy_o && status_o[SB_PROT]));

  // R5: protect drop ends the run at once
  a_r5_drop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    wp_drop |=> (!busy_o && (status_o[SB_PFAIL] || status_o[SB_EFAIL])));

  // R8: reset from a quiet state never raises busy
  a_r8_quiet_reset: assert property (@(posedge clk)
    (!rst_n && state_q != ST_BUSY && state_q != ST_ABORT) |=> !busy_o);

endmodule

// File: tb/pe_status_ctrl_bench.sv
module pe_status_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_N  = 4;
  localparam int ERASE_N = 10;
  localparam int ABORT_N = 2;

  // {op[6:4], wp[3], expect reject[2], expect busy[1], expect bit3[0]}
  localparam logic [6:0] VEC [0:9] = '{
    7'b001_1_0_1_0, 7'b010_1_0_1_0, 7'b001_0_0_0_1, 7'b010_0_0_0_1,
    7'b011_1_1_0_0, 7'b100_1_1_0_0, 7'b101_1_0_0_0, 7'b000_1_1_0_0,
    7'b110_1_1_0_0, 7'b111_1_1_0_0
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic       wp_en;
  logic       busy_o;
  logic [7:0] status_o;
  logic       cmd_reject_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_status_ctrl #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N), .ABORT_CYCLES(ABORT_N))
    u_pe_status_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .wp_en(wp_en), .busy_o(busy_o), .status_o(status_o), .cmd_reject_o(cmd_reject_o));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  function automatic int count_busy_dummy(input int x);
    return x;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; wp_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset busy", busy_o, 0);
    check("R1 reset status", status_o, 8'h80);
    check("R2 reset reject", cmd_reject_o, 0);

    // table walk from idle
    foreach (VEC[i]) begin
      string tag;
      tag = (VEC[i][6:4] == 3'd1 || VEC[i][6:4] == 3'd2) ? (VEC[i][3] ? "R1 vec" : "R4 vec")
          : (VEC[i][6:4] == 3'd5) ? "R6 vec" : "R9 vec";
      wp_en = VEC[i][3];
      issue(VEC[i][6:4]);
      check({tag, " reject"}, cmd_reject_o, VEC[i][2]);
      check({tag, " busy"},   busy_o,       VEC[i][1]);
      check({tag, " bit3"},   status_o[3],  VEC[i][0]);
      wp_en = 1'b1;
      wait_idle();
      issue(3'd5);
    end

    // R1: program and erase lengths, ready bit
    issue(3'd1);
    check("R1 ready low", status_o[7], 0);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    check("R1 program length", n, PROG_N);
    check("R1 ready high", status_o[7], 1);
    issue(3'd2);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    check("R1 erase length", n, ERASE_N);

    // R2 / R6: refusals while running
    issue(3'd2);
    issue(3'd1);
    check("R2 reject pulse", cmd_reject_o, 1);
    check("R2 still busy", busy_o, 1);
    @(negedge clk);
    check("R2 pulse one cycle", cmd_reject_o, 0);
    issue(3'd5);
    check("R6 clear refused busy", cmd_reject_o, 1);
    wait_idle();

    // R3: suspend / resume with count preserved
    issue(3'd1);
    n = 1;
    @(negedge clk); n++;
    issue(3'd3);
    check("R3 busy released", busy_o, 0);
    check("R3 suspend bit", status_o[6], 1);
    repeat (3) @(negedge clk);
    check("R3 held", busy_o, 0);
    issue(3'd1);
    check("R9 program in suspend", cmd_reject_o, 1);
    issue(3'd3);
    check("R9 suspend in suspend", cmd_reject_o, 1);
    issue(3'd5);
    check("R6 clear in suspend", cmd_reject_o, 0);
    issue(3'd4);
    check("R3 suspend bit off", status_o[6], 0);
    begin
      int m;
      m = 0;
      while (busy_o) begin m++; @(negedge clk); end
      check("R3 remaining length", m, PROG_N - (n - 1));
    end

    // R4 / R6: sticky protect bit
    wp_en = 1'b0;
    issue(3'd1);
    wp_en = 1'b1;
    check("R4 no busy", busy_o, 0);
    issue(3'd1);
    wait_idle();
    check("R6 bit3 sticky", status_o[3], 1);
    issue(3'd5);
    check("R6 bit3 cleared", status_o[3], 0);

    // R5: protect drop mid-run
    issue(3'd2);
    @(negedge clk);
    wp_en = 1'b0;
    @(negedge clk);
    check("R5 erase stopped", busy_o, 0);
    check("R5 erase fail", status_o[5:4], 2'b10);
    wp_en = 1'b1;
    issue(3'd1);
    wp_en = 1'b0;
    @(negedge clk);
    wp_en = 1'b1;
    check("R5 program fail", status_o[5:4], 2'b11);
    issue(3'd5);
    check("R6 fail bits cleared", status_o, 8'h80);

    // R7: reset while running
    wp_en = 1'b0;
    issue(3'd1);
    wp_en = 1'b1;
    issue(3'd2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    check("R7 drain length", n, ABORT_N);
    check("R7 errors cleared", status_o, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset while suspended, commands during reset
    issue(3'd1);
    issue(3'd3);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 susp reset busy", busy_o, 0);
    check("R8 susp reset status", status_o, 8'h80);
    issue(3'd2);
    check("R8 cmd in reset", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd4);
    check("R8 resume discarded", cmd_reject_o, 1);
    check("R8 resume no busy", busy_o, count_busy_dummy(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule